// File: doc/BRIEF.md
# Quad-I/O Flash Read Engine

The engine is the master side of a serial NOR flash link. It carries out one quad-I/O fast read per request, in single-data-rate mode. The host places a start address, a byte count and two options on the inputs and pulses `start_i`. The options select 32-bit addressing and a busy poll before the read.

The engine drives chip select and a serial clock at half the system clock rate. It first sends the read opcode on one line, then the address and a mode byte on four lines. The mode byte has its own phase of two clocks, so the dummy count stays at the device's true figure of four. After the dummy clocks it releases the lines, takes in nibbles and hands out whole bytes with a one-cycle strobe.

When polling is enabled, the engine first runs status-register frames until the busy bit reads clear. A chip-select-high gap of programmable length separates any two frames.

Top module: `qspi_rd_engine`

## Requirements
- R1: After reset and whenever the engine is idle, `cs_no` is high, `sck_o` is low, `io_oe_o` is 0 and `busy_o` is low.
- R2: A start with a length of 0 or above 256 pulses `err_o` for exactly one cycle, in the cycle after the start is sampled. It causes no chip-select activity, no `done_o` and no `busy_o`.
- R3: `cs_no` falls while `sck_o` is low. The first rising edge of `sck_o` follows one system cycle later. Each serial clock lasts two system cycles, a low half and then a high half. `sck_o` is high only while `cs_no` is low.
- R4: With `poll_en_i` set, the engine first runs a status frame. This frame sends opcode 0x05 MSB first on `io_o[0]` (`io_oe_o` = 0001) over 8 clocks. It then runs 8 clocks with `io_oe_o` = 0, capturing the status MSB first from `io_i[1]`. If status bit 0 is 1, the frame repeats; otherwise the read frame follows.
- R5: A read frame opens with opcode 0xEB, MSB first on `io_o[0]`, over 8 clocks with `io_oe_o` = 0001.
- R6: The address follows on four lines with `io_oe_o` = 1111, most significant nibble first, and `io_o[3]` carries each nibble's MSB. When `addr4b_i` is 0 it takes 6 clocks with `addr_i[23:0]`. When `addr4b_i` is 1 it takes 8 clocks with `addr_i[31:0]`.
- R7: A mode phase of 2 clocks follows the address, with `io_oe_o` = 1111. Its nibbles are 0xF and then 0x0, so continuous-read mode is never entered.
- R8: Exactly 4 dummy clocks follow the mode phase, with `io_oe_o` = 0. The first data nibble is taken at the next rising edge.
- R9: Data nibbles are sampled from `io_i` at rising clock edges, high nibble first, two clocks per byte. Each byte appears on `data_o` with a one-cycle `data_vld_o`, and exactly the requested number of bytes are delivered in address order. The read frame has 14 + address clocks + 2 x length clocks in all.
- R10: `done_o` pulses for one cycle in the first cycle that `cs_no` is high after the data. This is the same cycle as the last byte's `data_vld_o`.
- R11: Between frames, `cs_no` stays high for at least max(`desel_cyc_i`, 1) cycles, and `busy_o` stays high through the final gap. A start, valid or not, that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled while idle |
| addr_i | input | 32 | Start address |
| len_i | input | 9 | Byte count, valid range 1 to 256 |
| addr4b_i | input | 1 | 1 selects 32-bit addressing, 0 selects 24-bit |
| poll_en_i | input | 1 | 1 runs busy polling before the read |
| desel_cyc_i | input | 4 | Minimum chip-select-high cycles between frames (0 acts as 1) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse at the end of the read |
| err_o | output | 1 | One-cycle pulse when a length is rejected |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_o | output | 4 | Output values of the I/O lines |
| io_oe_o | output | 4 | Per-line output enable |
| io_i | input | 4 | Input values of the I/O lines |
| data_o | output | 8 | Received byte |
| data_vld_o | output | 1 | `data_o` holds a new byte |

## Verification
The assertions assume only that reset starts the engine. They place no condition on `io_i`, on the timing of `start_i` or on the length value, so they must hold even for rejected or mid-transfer requests.

The bench's flash model changes `io_i` only while `sck_o` is low. This keeps every sampled nibble stable across its capture edge. The model also decodes the address from the bus itself, so the data check does not depend on the engine's own address handling.

Start pulses last one cycle. They cover lengths inside and outside the valid range, and one extra pulse with an invalid length arrives in the middle of a transfer.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_POP, S_PRD, S_PGAP, S_ROP, S_ADR, S_MOD, S_DUM, S_DAT, S_GAP
  } qrd_state_e;

  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_READ = 8'hEB;
  localparam int unsigned MODE_CLKS = 2;
endpackage

// File: rtl/qspi_rd_ctrl.sv
module qspi_rd_ctrl
  import qspi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 9,
  parameter int unsigned MAX_LEN    = 256,
  parameter int unsigned DUMMY_CLKS = 4,
  parameter int unsigned GAP_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             addr4b_i,
  input  logic             poll_en_i,
  input  logic [GAP_W-1:0] desel_cyc_i,
  input  logic             busy_bit_i,
  output qrd_state_e       st_q_o,
  output qrd_state_e       st_d_o,
  output logic             ph_o,
  output logic             a4_o,
  output logic             accept_o,
  output logic             err_o,
  output logic             done_o,
  output logic             cs_no,
  output logic             sck_o
);
  localparam int unsigned CNT_W = LEN_W + 1;

  qrd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, gap_ld;
  logic             ph_q, ph_d;
  logic [LEN_W-1:0] len_q;
  logic [GAP_W-1:0] gap_q;
  logic             a4_q, len_ok, accept;
  logic             err_q, done_q;

  assign len_ok = (len_i != '0) && (len_i <= LEN_W'(MAX_LEN));
  assign accept = (st_q == S_IDLE) && start_i && len_ok;
  assign gap_ld = (gap_q == '0) ? '0 : CNT_W'(gap_q) - 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          st_d  = poll_en_i ? S_POP : S_ROP;
          cnt_d = CNT_W'(7);
          ph_d  = 1'b0;
        end
      end
      S_PGAP: begin
        if (cnt_q == '0) begin
          st_d  = busy_bit_i ? S_POP : S_ROP;
          cnt_d = CNT_W'(7);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_GAP: begin
        if (cnt_q == '0) st_d = S_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: begin
        ph_d = ~ph_q;
        // phase change only at the end of a high half
        if (ph_q) begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else begin
            unique case (st_q)
              S_POP: begin st_d = S_PRD;  cnt_d = CNT_W'(7); end
              S_PRD: begin st_d = S_PGAP; cnt_d = gap_ld; end
              S_ROP: begin
                st_d  = S_ADR;
                cnt_d = a4_q ? CNT_W'(ADDR_W/4 - 1) : CNT_W'((ADDR_W-8)/4 - 1);
              end
              S_ADR: begin st_d = S_MOD; cnt_d = CNT_W'(MODE_CLKS - 1); end
              S_MOD: begin st_d = S_DUM; cnt_d = CNT_W'(DUMMY_CLKS - 1); end
              S_DUM: begin st_d = S_DAT; cnt_d = {len_q, 1'b0} - 1'b1; end
              default: begin st_d = S_GAP; cnt_d = gap_ld; end
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      len_q  <= '0;
      gap_q  <= '0;
      a4_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      err_q  <= (st_q == S_IDLE) && start_i && !len_ok;
      done_q <= (st_q == S_DAT) && (st_d == S_GAP);
      if (accept) begin
        len_q <= len_i;
        gap_q <= desel_cyc_i;
        a4_q  <= addr4b_i;
      end
    end
  end

  assign st_q_o   = st_q;
  assign st_d_o   = st_d;
  assign ph_o     = ph_q;
  assign a4_o     = a4_q;
  assign accept_o = accept;
  assign err_o    = err_q;
  assign done_o   = done_q;
  assign cs_no    = (st_q inside {S_IDLE, S_PGAP, S_GAP});
  assign sck_o    = ph_q;
endmodule

// File: rtl/qspi_rd_tx.sv
module qspi_rd_tx
  import qspi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [7:0]  MODE_VAL = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              a4_i,
  input  qrd_state_e        st_q_i,
  input  qrd_state_e        st_d_i,
  input  logic              ph_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o
);
  localparam int unsigned PAD_W = ADDR_W - 8;

  logic [ADDR_W-1:0] sr_q, addr_q, ld_val;
  logic              load, shift, single;

  assign load   = (st_d_i != st_q_i) && (st_d_i inside {S_POP, S_ROP, S_ADR, S_MOD});
  assign shift  = (st_d_i == st_q_i) && ph_i;
  assign single = (st_q_i inside {S_POP, S_ROP});

  always_comb begin
    unique case (st_d_i)
      S_POP:   ld_val = {OP_STAT, {PAD_W{1'b0}}};
      S_ROP:   ld_val = {OP_READ, {PAD_W{1'b0}}};
      S_ADR:   ld_val = a4_i ? addr_q : {addr_q[PAD_W-1:0], 8'h00};
      default: ld_val = {MODE_VAL, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      addr_q <= '0;
    end else begin
      if (accept_i) addr_q <= addr_i;
      if (load)       sr_q <= ld_val;
      else if (shift) sr_q <= single ? (sr_q << 1) : (sr_q << 4);
    end
  end

  always_comb begin
    io_o    = 4'h0;
    io_oe_o = 4'h0;
    if (single) begin
      io_o    = {3'b000, sr_q[ADDR_W-1]};
      io_oe_o = 4'h1;
    end else if (st_q_i inside {S_ADR, S_MOD}) begin
      io_o    = sr_q[ADDR_W-1 -: 4];
      io_oe_o = 4'hF;
    end
  end
endmodule

// File: rtl/qspi_rd_rx.sv
module qspi_rd_rx
  import qspi_rd_pkg::*;
#(
  parameter int unsigned BUSY_BIT = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  qrd_state_e st_q_i,
  input  logic       ph_i,
  input  logic [3:0] io_i,
  output logic       busy_bit_o,
  output logic [7:0] data_o,
  output logic       data_vld_o
);
  logic [7:0] stat_q, data_q;
  logic [3:0] hi_q;
  logic       nib_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      data_q <= '0;
      hi_q   <= '0;
      nib_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (st_q_i == S_IDLE) nib_q <= 1'b0;
      // capture at the close of the high half
      if (ph_i && st_q_i == S_PRD) stat_q <= {stat_q[6:0], io_i[1]};
      if (ph_i && st_q_i == S_DAT) begin
        if (!nib_q) begin
          hi_q  <= io_i;
          nib_q <= 1'b1;
        end else begin
          data_q <= {hi_q, io_i};
          vld_q  <= 1'b1;
          nib_q  <= 1'b0;
        end
      end
    end
  end

  assign busy_bit_o = stat_q[BUSY_BIT];
  assign data_o     = data_q;
  assign data_vld_o = vld_q;
endmodule

// File: rtl/qspi_rd_engine.sv
module qspi_rd_engine
  import qspi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 9,
  parameter int unsigned MAX_LEN    = 256,
  parameter int unsigned DUMMY_CLKS = 4,
  parameter int unsigned GAP_W      = 4,
  parameter int unsigned BUSY_BIT   = 0,
  parameter logic [7:0]  MODE_VAL   = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              addr4b_i,
  input  logic              poll_en_i,
  input  logic [GAP_W-1:0]  desel_cyc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_no,
  output logic              sck_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i,
  output logic [7:0]        data_o,
  output logic              data_vld_o
);
  qrd_state_e st_q, st_d;
  logic       ph, a4, accept, busy_bit;

  qspi_rd_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
    .DUMMY_CLKS(DUMMY_CLKS), .GAP_W(GAP_W)
  ) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .addr4b_i(addr4b_i), .poll_en_i(poll_en_i), .desel_cyc_i(desel_cyc_i),
    .busy_bit_i(busy_bit), .st_q_o(st_q), .st_d_o(st_d), .ph_o(ph),
    .a4_o(a4), .accept_o(accept), .err_o(err_o), .done_o(done_o),
    .cs_no(cs_no), .sck_o(sck_o)
  );

  qspi_rd_tx #(.ADDR_W(ADDR_W), .MODE_VAL(MODE_VAL)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .addr_i(addr_i),
    .a4_i(a4), .st_q_i(st_q), .st_d_i(st_d), .ph_i(ph),
    .io_o(io_o), .io_oe_o(io_oe_o)
  );

  qspi_rd_rx #(.BUSY_BIT(BUSY_BIT)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_q_i(st_q), .ph_i(ph), .io_i(io_i),
    .busy_bit_o(busy_bit), .data_o(data_o), .data_vld_o(data_vld_o)
  );

  assign busy_o = (st_q != S_IDLE);
endmodule

// File: rtl/qspi_rd_engine_chk.sv
module qspi_rd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       cs_no,
  input logic       sck_o,
  input logic [3:0] io_oe_o,
  input logic       data_vld_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sck_o && io_oe_o == 4'h0));
  // R2
  err_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && !busy_o && !done_o));
  // R3
  sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  // R3
  cs_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sck_o);
  // R6
  oe_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o inside {4'h0, 4'h1, 4'hF});
  // R9
  vld_after_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(!cs_no));
  // R10
  done_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(!cs_no) && data_vld_o));
endmodule

bind qspi_rd_engine qspi_rd_engine_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .cs_no(cs_no), .sck_o(sck_o), .io_oe_o(io_oe_o),
  .data_vld_o(data_vld_o)
);

// File: tb/test_qspi_rd_engine.sv
`timescale 1ns/1ps
module test_qspi_rd_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [8:0]  len_i = '0;
  logic        addr4b_i = 1'b0;
  logic        poll_en_i = 1'b0;
  logic [3:0]  desel_cyc_i = '0;
  logic [3:0]  io_i = '0;
  logic        busy_o, done_o, err_o, cs_no, sck_o, data_vld_o;
  logic [3:0]  io_o, io_oe_o;
  logic [7:0]  data_o;

  qspi_rd_engine i_qspi_rd_engine (
    .clk_i, .rst_ni, .start_i, .addr_i, .len_i, .addr4b_i, .poll_en_i,
    .desel_cyc_i, .busy_o, .done_o, .err_o, .cs_no, .sck_o, .io_o,
    .io_oe_o, .io_i, .data_o, .data_vld_o
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ecnt = 0, cs_hi = 0, gmin = 1, fall_cyc = 0, last_rise = 0;
  int txn_frames = 0, frames_total = 0, stat_frames = 0, busy_left = 0;
  int exp_len = 0, got = 0, err_cnt = 0;
  bit m_a4 = 0, cur_status = 0, cur_busy = 0, next_is_status = 0;
  bit done_seen = 0, prev_cs = 1, prev_sck = 0;
  logic [31:0] fa = '0, m_addr = '0;
  logic [7:0]  expq[$];
  localparam logic [7:0] STAT_OP = 8'h05;
  localparam logic [7:0] READ_OP = 8'hEB;

  function automatic logic [7:0] mem(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[31:24] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] taddr(input logic [31:0] a, input int k, input bit w4);
    logic [31:0] s = a + 32'(k);
    return w4 ? s : (s & 32'h00FF_FFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model and per-edge reference
  always @(negedge clk_i) if (rst_ni) begin
    int na, n, k;
    logic [31:0] en;
    logic [7:0] b, sb;
    cyc++;
    na = m_a4 ? 8 : 6;
    if (err_o) err_cnt++;
    if (prev_cs && !cs_no) begin
      chk(!sck_o, "R3 cs falls with sck low", 32'(sck_o), 0);
      if (txn_frames > 0) chk(cs_hi >= gmin, "R11 deselect gap", cs_hi, gmin);
      txn_frames++; frames_total++;
      cur_status = next_is_status;
      cur_busy = (busy_left > 0);
      ecnt = 0; fa = '0; fall_cyc = cyc;
    end
    if (!prev_cs && cs_no) begin
      n = cur_status ? 16 : 14 + na + 2 * exp_len;
      chk(ecnt == n, cur_status ? "R4 status frame clocks" : "R9 read frame clocks", ecnt, n);
      if (cur_status) begin
        stat_frames++;
        if (cur_busy) busy_left--;
        next_is_status = cur_busy;
      end
    end
    if (cs_no) cs_hi++; else cs_hi = 0;
    if (sck_o && !prev_sck) begin
      ecnt++;
      if (ecnt == 1) chk(cyc - fall_cyc == 1, "R3 first edge half clock after cs", cyc - fall_cyc, 1);
      else chk(cyc - last_rise == 2, "R3 clock period", cyc - last_rise, 2);
      last_rise = cyc;
      if (cur_status) begin
        if (ecnt <= 8) begin
          chk(io_oe_o == 4'h1, "R4 status opcode oe", io_oe_o, 1);
          chk(io_o[0] == STAT_OP[8-ecnt], "R4 status opcode bit", io_o[0], STAT_OP[8-ecnt]);
        end else chk(io_oe_o == 4'h0, "R4 status read oe", io_oe_o, 0);
      end else if (ecnt <= 8) begin
        chk(io_oe_o == 4'h1, "R5 opcode oe", io_oe_o, 1);
        chk(io_o[0] == READ_OP[8-ecnt], "R5 opcode bit", io_o[0], READ_OP[8-ecnt]);
      end else if (ecnt <= 8 + na) begin
        en = (taddr(m_addr, 0, m_a4) >> (4 * (8 + na - ecnt))) & 32'hF;
        chk(io_oe_o == 4'hF, "R6 address oe", io_oe_o, 4'hF);
        chk(32'(io_o) == en, "R6 address nibble", io_o, en);
        fa = {fa[27:0], io_o};
      end else if (ecnt <= 10 + na) begin
        en = (ecnt == 9 + na) ? 32'hF : 32'h0;
        chk(io_oe_o == 4'hF, "R7 mode oe", io_oe_o, 4'hF);
        chk(32'(io_o) == en, "R7 mode nibble", io_o, en);
      end else if (ecnt <= 14 + na) begin
        chk(io_oe_o == 4'h0, "R8 dummy lines released", io_oe_o, 0);
      end else begin
        chk(io_oe_o == 4'h0, "R9 data lines released", io_oe_o, 0);
      end
    end
    // drive next nibble during the low half
    if (cs_no) io_i = 4'h0;
    else if (!sck_o) begin
      n = ecnt + 1;
      io_i = 4'h0;
      if (cur_status) begin
        sb = cur_busy ? 8'h03 : 8'h02;
        if (n >= 9 && n <= 16) io_i = {2'b00, sb[16-n], 1'b0};
      end else if (n >= 15 + na) begin
        k = n - 15 - na;
        b = mem(taddr(fa, k / 2, m_a4));
        io_i = (k % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
    if (data_vld_o) begin
      if (expq.size() == 0) chk(0, "R9 unexpected byte", data_o, 0);
      else begin
        b = expq.pop_front();
        chk(data_o == b, "R9 data byte", data_o, b);
      end
      got++;
    end
    if (done_o) begin
      chk(cs_no, "R10 done with cs high", cs_no, 1);
      chk(data_vld_o, "R10 last byte with done", data_vld_o, 1);
      done_seen = 1;
    end
    prev_cs = cs_no;
    prev_sck = sck_o;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic errt(input int l);
    int f0;
    @(negedge clk_i);
    len_i = 9'(l); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    f0 = frames_total;
    chk(err_o, "R2 error pulse", err_o, 1);
    chk(!busy_o, "R2 stays idle", busy_o, 0);
    @(negedge clk_i);
    chk(!err_o, "R2 pulse is one cycle", err_o, 0);
    repeat (6) @(negedge clk_i);
    chk(frames_total == f0 && cs_no && !done_o, "R2 no bus activity", frames_total, f0);
  endtask

  task automatic run(input logic [31:0] a, input int n, input bit w4, input bit poll,
                     input int nb, input int g, input bit poke);
    int t, e0;
    m_a4 = w4; m_addr = a; exp_len = n; busy_left = nb; next_is_status = poll;
    stat_frames = 0; txn_frames = 0; got = 0; done_seen = 0;
    gmin = (g == 0) ? 1 : g;
    for (int k = 0; k < n; k++) expq.push_back(mem(taddr(a, k, w4)));
    @(negedge clk_i);
    addr_i = a; len_i = 9'(n); addr4b_i = w4; poll_en_i = poll;
    desel_cyc_i = 4'(g); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R11 busy after start", busy_o, 1);
    e0 = err_cnt;
    if (poke) begin
      repeat (20) @(negedge clk_i);
      start_i = 1'b1; len_i = '0; addr_i = ~a;
      @(negedge clk_i);
      start_i = 1'b0; len_i = 9'(n);
    end
    t = 0;
    while (!done_seen && t < 20000) begin @(negedge clk_i); t++; end
    chk(done_seen, "R10 done seen", done_seen, 1);
    chk(got == n, "R9 byte count", got, n);
    chk(stat_frames == (poll ? nb + 1 : 0), "R4 status frame count", stat_frames, poll ? nb + 1 : 0);
    chk(txn_frames == stat_frames + 1, "R11 single read frame", txn_frames, stat_frames + 1);
    chk(expq.size() == 0, "R9 all bytes delivered", expq.size(), 0);
    if (poke) chk(err_cnt == e0, "R11 start ignored while busy", err_cnt, e0);
    @(negedge clk_i);
    if (g > 1) chk(busy_o, "R11 busy through final gap", busy_o, 1);
    t = 0;
    while (busy_o && t < 100) begin @(negedge clk_i); t++; end
    chk(!busy_o && cs_no && io_oe_o == 4'h0, "R1 idle after transfer", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no && !sck_o && io_oe_o == 4'h0 && !busy_o && !done_o && !err_o && !data_vld_o,
        "R1 reset state", {cs_no, sck_o, io_oe_o, busy_o}, 32'h40);
    errt(0);
    errt(257);
    run(32'hAB12_3450, 1, 1'b0, 1'b0, 0, 0, 1'b0);
    run(32'h1234_5678, 5, 1'b1, 1'b1, 2, 3, 1'b0);
    run(32'h00FF_FF00, 256, 1'b0, 1'b1, 0, 7, 1'b0);
    run(32'h0000_0100, 2, 1'b0, 1'b0, 0, 15, 1'b1);
    run(32'hFFFF_FFF0, 3, 1'b1, 1'b1, 1, 0, 1'b0);
    errt(511);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule